// File: doc/BRIEF.md
# Nested Priority Interrupt Arbiter

This block decides which of a small set of interrupt request lines may interrupt the running code of a small CPU. Each request line carries a fixed priority level equal to its index, and a lower number means a higher priority. The block keeps the current priority level of the running code, with main-program code at the lowest priority. A request is granted only when its level number is strictly below that current level, and only while the global enable bit is set.

A grant raises a one-cycle acknowledge that names the winning line. It also moves the current level to the level of the request and clears the global enable bit. The level being left is recorded in a nesting register that holds one bit per level. Software re-enables nesting inside a routine with an enable pulse. A return pulse starts a fixed pop sequence of one step per cycle: flag word, code-segment register (only when its save flag is set), program-counter high byte, program-counter low byte. At the end of the sequence the block restores the lowest-numbered recorded level and sets the global enable bit again. If a routine never issues the enable pulse, nothing nests and the arbitration behaves as plain non-nested arbitration.

Top module: `nest_irq_arb`

## Requirements
- R1: In reset and in the first cycle after reset, the current level is NUM_LVL-1 (7 by default), the global enable is 0, no acknowledge is raised, the pop step is 0 and the nesting register is empty.
- R2: The enable pulse sets the global enable from the next cycle. A grant needs the enable to be 1 in the cycle it is decided. A grant clears the enable, even when an enable pulse arrives in the same cycle.
- R3: Request line i has level i. It is granted only when i is strictly less than the current level. A request at the current level or above it stays pending and gets no acknowledge.
- R4: When several requests are eligible, the lowest index wins. The acknowledge is one-hot on ack_o, with the index on ack_id_o. It is raised for exactly one cycle, in the cycle after the inputs that caused it.
- R5: From the cycle of the acknowledge, the current level equals the granted index. The level that was left is recorded in the nesting register.
- R6: A return pulse starts a pop sequence with one step per cycle. The step codes on pop_step_o are 1 = flag word, 2 = code-segment register, 3 = PC high byte, 4 = PC low byte and 0 = idle. Step 2 appears only if csr_save_i was 1 in the cycle of the return pulse.
- R7: In the cycle after step 4, the current level becomes the lowest-numbered recorded level, and that record is cleared. When no level is recorded, the current level becomes NUM_LVL-1. In both cases the global enable becomes 1.
- R8: No grant is made in the cycle of a return pulse or while the pop sequence runs. A return pulse during the sequence has no effect on the order of its steps, and it does not restart the sequence.
- R9: Inside a routine that has issued the enable pulse, a pending request with a lower level number is granted. A request with a higher level number waits until returns restore a current level above it.
- R10: When a routine issues no enable pulse, a pending request is not granted until that routine's return has completed. The arbitration then behaves as plain non-nested arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | NUM_LVL | Level-sensitive request lines, index = priority level |
| ei_i | input | 1 | Enable-interrupts pulse |
| iret_i | input | 1 | Return-from-interrupt pulse |
| csr_save_i | input | 1 | Code-segment register was saved, include its pop step |
| ack_o | output | NUM_LVL | One-hot acknowledge pulse |
| ack_id_o | output | $clog2(NUM_LVL) | Index of the acknowledged request |
| cpl_o | output | $clog2(NUM_LVL) | Current priority level |
| ien_o | output | 1 | Global interrupt enable |
| pop_step_o | output | 3 | Current pop step of the return sequence |

## Verification
The bench builds the block with the default NUM_LVL of 8. Every level from 0 to 7 can be requested, and main code sits at level 7. This width allows nesting three deep (7 to 5 to 2 to 0) and then unwinding through the nesting register, with the pop sequence run both with and without the code-segment step. At this width the bench also reaches a return with an empty nesting register, a request at exactly the current level, a return pulse that coincides with an eligible request, and an enable pulse that coincides with a grant.

// File: rtl/nia_pkg.sv
package nia_pkg;
  typedef enum logic [2:0] {
    STEP_IDLE  = 3'd0,
    STEP_FLAGS = 3'd1,
    STEP_CSR   = 3'd2,
    STEP_PC_HI = 3'd3,
    STEP_PC_LO = 3'd4
  } pop_step_e;
endpackage

// File: rtl/nia_prio_pick.sv
// Lowest-index set bit finder.
module nia_prio_pick #(
  parameter int N  = 8,
  localparam int LW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec_i,
  output logic          valid_o,
  output logic [LW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = LW'(i);
    end
  end

  assign valid_o = |vec_i;
endmodule

// File: rtl/nia_nest_reg.sv
// One bit per level left by a grant; pop yields lowest set level.
module nia_nest_reg #(
  parameter int N  = 8,
  localparam int LW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [LW-1:0] push_lvl_i,
  input  logic          pop_i,
  output logic [LW-1:0] restore_lvl_o
);
  logic [N-1:0]  nest_q;
  logic          any_set;
  logic [LW-1:0] low_idx;

  nia_prio_pick #(.N(N)) u_pick (
    .vec_i  (nest_q),
    .valid_o(any_set),
    .idx_o  (low_idx)
  );

  assign restore_lvl_o = any_set ? low_idx : LW'(N - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nest_q <= '0;
    end else if (push_i) begin
      nest_q[push_lvl_i] <= 1'b1;
    end else if (pop_i && any_set) begin
      nest_q[low_idx] <= 1'b0;
    end
  end

  // R5: a level being left is never already recorded
  a_r5_push_fresh: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !nest_q[push_lvl_i]);
  // R8: grant and return completion never coincide
  a_r8_no_push_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i));
endmodule

// File: rtl/nia_ret_seq.sv
// Return pop sequencer: flags, optional CSR, PC high, PC low.
module nia_ret_seq
  import nia_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      csr_en_i,
  output logic      busy_o,
  output logic      done_o,
  output pop_step_e step_o
);
  pop_step_e step_q, step_d;
  logic      csr_q;

  always_comb begin
    step_d = step_q;
    unique case (step_q)
      STEP_IDLE:  if (start_i) step_d = STEP_FLAGS;
      STEP_FLAGS: step_d = csr_q ? STEP_CSR : STEP_PC_HI;
      STEP_CSR:   step_d = STEP_PC_HI;
      STEP_PC_HI: step_d = STEP_PC_LO;
      STEP_PC_LO: step_d = STEP_IDLE;
      default:    step_d = STEP_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= STEP_IDLE;
      csr_q  <= 1'b0;
    end else begin
      step_q <= step_d;
      if (step_q == STEP_IDLE && start_i) csr_q <= csr_en_i;
    end
  end

  assign busy_o = (step_q != STEP_IDLE);
  assign done_o = (step_q == STEP_PC_LO);
  assign step_o = step_q;

  a_r6_start_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == STEP_IDLE && start_i) |=> step_q == STEP_FLAGS);
  a_r6_after_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q == STEP_FLAGS |=> (step_q == STEP_CSR || step_q == STEP_PC_HI));
  a_r6_csr_from_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q == STEP_CSR |-> $past(step_q) == STEP_FLAGS);
  a_r6_hi_then_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q == STEP_PC_HI |=> step_q == STEP_PC_LO);
  a_r6_lo_then_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q == STEP_PC_LO |=> step_q == STEP_IDLE);
endmodule

// File: rtl/nest_irq_arb.sv
module nest_irq_arb
  import nia_pkg::*;
#(
  parameter int NUM_LVL = 8,
  localparam int LW = $clog2(NUM_LVL)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_LVL-1:0] req_i,
  input  logic               ei_i,
  input  logic               iret_i,
  input  logic               csr_save_i,
  output logic [NUM_LVL-1:0] ack_o,
  output logic [LW-1:0]      ack_id_o,
  output logic [LW-1:0]      cpl_o,
  output logic               ien_o,
  output logic [2:0]         pop_step_o
);
  localparam logic [LW-1:0] MAIN_LVL = LW'(NUM_LVL - 1);

  logic [LW-1:0]      cpl_q;
  logic               ien_q;
  logic [NUM_LVL-1:0] ack_q;
  logic [LW-1:0]      ack_id_q;

  logic [NUM_LVL-1:0] elig;
  logic               any_elig;
  logic [LW-1:0]      win_idx;
  logic               grant;
  logic               start;
  logic               busy;
  logic               done;
  logic [LW-1:0]      restore_lvl;
  pop_step_e          step;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_elig
    assign elig[g] = req_i[g] && (LW'(g) < cpl_q);
  end

  nia_prio_pick #(.N(NUM_LVL)) u_req_pick (
    .vec_i  (elig),
    .valid_o(any_elig),
    .idx_o  (win_idx)
  );

  assign grant = ien_q && any_elig && !busy && !iret_i;
  assign start = iret_i && !busy;

  nia_nest_reg #(.N(NUM_LVL)) u_nest (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (grant),
    .push_lvl_i   (cpl_q),
    .pop_i        (done),
    .restore_lvl_o(restore_lvl)
  );

  nia_ret_seq u_ret (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .csr_en_i(csr_save_i),
    .busy_o  (busy),
    .done_o  (done),
    .step_o  (step)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpl_q    <= MAIN_LVL;
      ien_q    <= 1'b0;
      ack_q    <= '0;
      ack_id_q <= '0;
    end else begin
      ack_q <= '0;
      if (grant) begin
        cpl_q    <= win_idx;
        ien_q    <= 1'b0;
        ack_q    <= NUM_LVL'(1) << win_idx;
        ack_id_q <= win_idx;
      end else if (done) begin
        cpl_q <= restore_lvl;
        ien_q <= 1'b1;
      end else if (ei_i) begin
        ien_q <= 1'b1;
      end
    end
  end

  assign ack_o      = ack_q;
  assign ack_id_o   = ack_id_q;
  assign cpl_o      = cpl_q;
  assign ien_o      = ien_q;
  assign pop_step_o = step;

  a_r2_grant_needs_ien: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ack_o) |-> $past(ien_q));
  a_r2_ien_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ack_o) |-> !ien_o);
  a_r3_req_below_cpl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ack_o) |-> (ack_id_o < $past(cpl_q)) && (($past(req_i) & ack_o) != '0));
  a_r4_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_o));
  a_r4_lowest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ack_o) |-> (($past(req_i) & (ack_o - NUM_LVL'(1))) == '0));
  a_r4_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ack_o) |=> (ack_o == '0));
  a_r5_cpl_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ack_o) |-> cpl_o == ack_id_o);
  a_r7_ien_after_ret: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> ien_q);
  a_r8_no_ack_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (ack_o == '0));
endmodule

// File: tb/nest_irq_arb_tb.sv
module nest_irq_arb_tb;
  localparam int N  = 8;
  localparam int LW = $clog2(N);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  req_i = '0;
  logic          ei_i = 1'b0, iret_i = 1'b0, csr_save_i = 1'b0;
  logic [N-1:0]  ack_o;
  logic [LW-1:0] ack_id_o, cpl_o;
  logic          ien_o;
  logic [2:0]    pop_step_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  nest_irq_arb #(.NUM_LVL(N)) u_dut (
    .clk_i, .rst_ni, .req_i, .ei_i, .iret_i, .csr_save_i,
    .ack_o, .ack_id_o, .cpl_o, .ien_o, .pop_step_o
  );

  // req[25:18] ei[17] iret[16] csr[15] | ack[14:7] cpl[6:4] ien[3] step[2:0]
  localparam int NV = 24;
  localparam logic [25:0] VEC [NV] = '{
    {8'h00, 3'b100, 8'h00, 3'd7, 1'b1, 3'd0},  // R2 enable
    {8'h20, 3'b000, 8'h20, 3'd5, 1'b0, 3'd0},  // R5 grant 5
    {8'h3C, 3'b000, 8'h00, 3'd5, 1'b0, 3'd0},  // R2 held, ien 0
    {8'h3C, 3'b100, 8'h00, 3'd5, 1'b1, 3'd0},
    {8'h3C, 3'b000, 8'h04, 3'd2, 1'b0, 3'd0},  // R9 R4 nest to 2
    {8'h7C, 3'b100, 8'h00, 3'd2, 1'b1, 3'd0},
    {8'h7C, 3'b000, 8'h00, 3'd2, 1'b1, 3'd0},  // R3 above waits
    {8'h7D, 3'b000, 8'h01, 3'd0, 1'b0, 3'd0},  // R9 nest to 0
    {8'h78, 3'b011, 8'h00, 3'd0, 1'b0, 3'd1},  // R6 with csr
    {8'h78, 3'b000, 8'h00, 3'd0, 1'b0, 3'd2},
    {8'h78, 3'b000, 8'h00, 3'd0, 1'b0, 3'd3},
    {8'h78, 3'b000, 8'h00, 3'd0, 1'b0, 3'd4},
    {8'h78, 3'b000, 8'h00, 3'd2, 1'b1, 3'd0},  // R7 back to 2
    {8'h78, 3'b000, 8'h00, 3'd2, 1'b1, 3'd0},
    {8'h78, 3'b010, 8'h00, 3'd2, 1'b1, 3'd1},  // R6 no csr
    {8'h78, 3'b000, 8'h00, 3'd2, 1'b1, 3'd3},
    {8'h78, 3'b000, 8'h00, 3'd2, 1'b1, 3'd4},
    {8'h78, 3'b000, 8'h00, 3'd5, 1'b1, 3'd0},  // R7 back to 5
    {8'h78, 3'b000, 8'h08, 3'd3, 1'b0, 3'd0},  // R4 3 beats 4
    {8'h70, 3'b010, 8'h00, 3'd3, 1'b0, 3'd1},  // R10 no ei, 4 waits
    {8'h70, 3'b000, 8'h00, 3'd3, 1'b0, 3'd3},
    {8'h70, 3'b000, 8'h00, 3'd3, 1'b0, 3'd4},
    {8'h70, 3'b000, 8'h00, 3'd5, 1'b1, 3'd0},
    {8'h70, 3'b000, 8'h10, 3'd4, 1'b0, 3'd0}   // R10 4 after return
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [N-1:0] r, input logic ei, input logic ir,
                     input logic cs);
    @(negedge clk_i);
    req_i = r; ei_i = ei; iret_i = ir; csr_save_i = cs;
    @(posedge clk_i);
    #1;
  endtask

  task automatic expect_out(input string tag, input int ack, input int cpl,
                            input int ien, input int step);
    chk({tag, " ack"}, int'(ack_o), ack);
    chk({tag, " cpl"}, int'(cpl_o), cpl);
    chk({tag, " ien"}, int'(ien_o), ien);
    chk({tag, " step"}, int'(pop_step_o), step);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; req_i = '0; ei_i = 0; iret_i = 0; csr_save_i = 0;
    #2;
    expect_out("R1 in reset", 0, 7, 0, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i);
    #1;
    expect_out("R1 after reset", 0, 7, 0, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();

    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VEC[i];
      cyc(v[25:18], v[17], v[16], v[15]);
      expect_out($sformatf("R3 R6 vec %0d", i), int'(v[14:7]), int'(v[6:4]),
                 int'(v[3]), int'(v[2:0]));
    end

    // R3: request at exactly the current level is not granted
    do_reset();
    cyc(8'h00, 1, 0, 0);
    cyc(8'h10, 0, 0, 0);
    expect_out("R5 grant 4", 8'h10, 4, 0, 0);
    chk("R4 ack id 4", int'(ack_id_o), 4);
    cyc(8'h00, 1, 0, 0);
    cyc(8'h10, 0, 0, 0);
    expect_out("R3 equal level", 0, 4, 1, 0);
    cyc(8'h20, 0, 0, 0);
    expect_out("R3 above level", 0, 4, 1, 0);

    // R8: second return pulse during sequence is ignored
    cyc(8'h00, 0, 1, 1);
    expect_out("R6 flags", 0, 4, 1, 1);
    cyc(8'h00, 0, 1, 0);
    expect_out("R8 csr kept", 0, 4, 1, 2);
    cyc(8'h00, 0, 0, 0);
    expect_out("R6 pc hi", 0, 4, 1, 3);
    cyc(8'h00, 0, 0, 0);
    expect_out("R6 pc lo", 0, 4, 1, 4);
    cyc(8'h00, 0, 0, 0);
    expect_out("R7 restore 7", 0, 7, 1, 0);
    cyc(8'h00, 0, 0, 0);
    expect_out("R8 no restart", 0, 7, 1, 0);

    // R8: return pulse blocks a grant; R7 empty nesting gives 7
    cyc(8'h02, 0, 1, 0);
    expect_out("R8 iret blocks", 0, 7, 1, 1);
    cyc(8'h02, 0, 0, 0);
    expect_out("R8 busy hi", 0, 7, 1, 3);
    cyc(8'h02, 0, 0, 0);
    expect_out("R8 busy lo", 0, 7, 1, 4);
    cyc(8'h02, 0, 0, 0);
    expect_out("R7 empty nest", 0, 7, 1, 0);
    cyc(8'h02, 0, 0, 0);
    expect_out("R4 grant 1", 8'h02, 1, 0, 0);
    chk("R4 ack id 1", int'(ack_id_o), 1);

    // R2: enable pulse coinciding with grant leaves enable clear
    cyc(8'h01, 1, 0, 0);
    expect_out("R2 ei", 0, 1, 1, 0);
    cyc(8'h01, 1, 0, 0);
    expect_out("R2 grant wins", 8'h01, 0, 0, 0);
    cyc(8'h01, 0, 0, 0);
    expect_out("R4 single pulse", 0, 0, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule